// File: doc/BRIEF.md
# Trigger-Qualified Gate Window Generator

This block turns a set of per-cycle trigger flags into a timed gate window. A programmable mask chooses which flags take part, and any selected flag that is high in a cycle counts as a trigger event. Counting from that event, the block waits a programmable number of cycles before it raises its gate. It then holds the gate until a second programmable offset, measured from the same event, is reached. All timing is in whole cycles of the processing clock. The gate can be inverted, and a downstream AND stage uses it to qualify other triggers.

Triggers that arrive while a window is pending or open are normally ignored, which gives the unit a dead time. When the retrigger option is set, such a trigger instead restarts the whole delay-and-open sequence from the new event. If the stop offset is not greater than the start offset, the unit runs through its delay and returns to idle without ever opening. The gate output comes from a flop, so the whole timing carries a fixed one-cycle latency.

Top module: `gate_delay_unit`

## Requirements
- R1: Bit i of `src_mask` enables trigger flag i. The flags are fixed by position: bits 0..7 are the two threshold units of each of the four analog channels in order (bit 0 = first channel unit 0, bit 1 = first channel unit 1, and so on up to bit 7), bit 8 is the time-to-digital input, bit 9 is the gate input and bit 10 is the first bus line. A trigger event is a cycle in which any enabled flag is high.
- R2: For a trigger sampled at clock edge T, with `negate` low, `gate_out` is high after edges T+start+1 through T+stop and low otherwise, so the window lasts stop-start cycles.
- R3: When `stop_dly` <= `start_dly`, a trigger never raises the gate.
- R4: With `negate` high, `gate_out` is the inverse of the R2 window (high while idle, low during the window).
- R5: With `retrig_en` low, triggers that arrive while a window is pending or open are ignored, and the original window completes unchanged.
- R6: With `retrig_en` high, a trigger during a pending or open window restarts both offsets from the new trigger edge.
- R7: While `rst_n` is low and directly after reset, `gate_out` is low and the unit is idle.
- R8: Flags whose mask bit is clear have no effect. With a zero mask, no flag pattern ever opens the gate.
- R9: Without retrigger, a trigger on the same edge on which the window closes is ignored. A trigger on the next edge is accepted as a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock; one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_flags | input | NUM_SRC | Per-cycle trigger flags, positions as in R1 |
| src_mask | input | NUM_SRC | Enable bit per trigger flag |
| start_dly | input | CNT_W | Cycles from the trigger to the gate opening |
| stop_dly | input | CNT_W | Cycles from the trigger to the gate closing |
| retrig_en | input | 1 | Restart the window on a trigger that arrives while it is busy |
| negate | input | 1 | Invert the gate polarity |
| gate_out | output | 1 | Registered gate window |

## Verification
The bench targets the exact edges of the window. A design with an off-by-one count would shift or stretch the high run and fail a cycle-by-cycle comparison, and a zero start offset is included to expose a missing latency cycle. It places a second trigger inside an open window with and without retrigger: a design that ignores the option would either cut the window short or never restart it. It triggers on the very edge the window closes and on the edge after: a design that accepts the first would produce a spurious window, and one that loses the second would miss a real event. It also runs equal and inverted offsets, where a naive comparison would open the gate for one cycle or wrap around.

// File: rtl/gd_pkg.sv
package gd_pkg;
   typedef enum logic [1:0] {
      GD_IDLE  = 2'd0,
      GD_DELAY = 2'd1,
      GD_OPEN  = 2'd2
   } gd_state_e;
endpackage

// File: rtl/gd_trig_select.sv
module gd_trig_select #(
   parameter int NUM_SRC = 16
) (
   input  logic [NUM_SRC-1:0] flags_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic               trig_o
);
   if (NUM_SRC < 1 || NUM_SRC > 32) begin : g_bad_src
      $error("gd_trig_select: NUM_SRC out of range");
   end

   logic [NUM_SRC-1:0] gated;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign gated[i] = flags_i[i] & mask_i[i];
   end

   assign trig_o = |gated;
endmodule

// File: rtl/gd_elapsed_ctr.sv
module gd_elapsed_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [CNT_W-1:0] cnt_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_w
      $error("gd_elapsed_ctr: CNT_W out of range");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else if (adv_i && cnt_o != CNT_MAX) begin
         cnt_o <= cnt_o + 1'b1;
      end
   end
endmodule

// File: rtl/gd_window_fsm.sv
module gd_window_fsm
   import gd_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_i,
   input  logic             retrig_en_i,
   input  logic             negate_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] stop_i,
   output logic             clr_o,
   output logic             adv_o,
   output gd_state_e        st_o,
   output logic             gate_o
);
   gd_state_e st, st_nxt;
   logic      restart;

   assign restart = trig_i && (st == GD_IDLE || retrig_en_i);

   always_comb begin
      st_nxt = st;
      unique case (st)
         GD_IDLE: begin
            if (trig_i) st_nxt = GD_DELAY;
         end
         GD_DELAY: begin
            if (restart)               st_nxt = GD_DELAY;
            else if (cnt_i >= start_i) st_nxt = (stop_i > start_i) ? GD_OPEN : GD_IDLE;
         end
         GD_OPEN: begin
            if (restart)               st_nxt = GD_DELAY;
            else if (cnt_i >= stop_i)  st_nxt = GD_IDLE;
         end
         default: st_nxt = GD_IDLE;
      endcase
   end

   assign clr_o = restart;
   assign adv_o = (st != GD_IDLE) && !restart;
   assign st_o  = st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= GD_IDLE;
         gate_o <= 1'b0;
      end else begin
         st     <= st_nxt;
         gate_o <= (st_nxt == GD_OPEN) ^ negate_i;
      end
   end

   logic is_open;
   assign is_open = (st == GD_OPEN);

   // R2
   open_after_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_open) |-> $past(st) == GD_DELAY);

   // R5
   dead_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!retrig_en_i && st == GD_OPEN && trig_i && cnt_i < stop_i) |=> st == GD_OPEN);

   // R3
   never_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == GD_DELAY && !(trig_i && retrig_en_i) && cnt_i >= start_i && stop_i <= start_i)
      |=> st == GD_IDLE);
endmodule

// File: rtl/gate_delay_unit.sv
module gate_delay_unit
   import gd_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int CNT_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] trig_flags,
   input  logic [NUM_SRC-1:0] src_mask,
   input  logic [CNT_W-1:0]   start_dly,
   input  logic [CNT_W-1:0]   stop_dly,
   input  logic               retrig_en,
   input  logic               negate,
   output logic               gate_out
);
   logic             trig, clr, adv;
   logic [CNT_W-1:0] cnt;
   gd_state_e        st;

   gd_trig_select #(.NUM_SRC(NUM_SRC)) u_sel (
      .flags_i (trig_flags),
      .mask_i  (src_mask),
      .trig_o  (trig)
   );

   gd_elapsed_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .adv_i (adv),
      .cnt_o (cnt)
   );

   gd_window_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .retrig_en_i (retrig_en),
      .negate_i    (negate),
      .cnt_i       (cnt),
      .start_i     (start_dly),
      .stop_i      (stop_dly),
      .clr_o       (clr),
      .adv_o       (adv),
      .st_o        (st),
      .gate_o      (gate_out)
   );

   // R6
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (retrig_en && (trig_flags & src_mask) != '0) |=> (st == GD_DELAY && cnt == '0));

   // R8
   masked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == GD_IDLE && (trig_flags & src_mask) == '0) |=> st == GD_IDLE);
endmodule

// File: tb/gate_delay_unit_bench.sv
module gate_delay_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 16;
   localparam int CW   = 16;
   localparam int SPAN = 32;
   localparam int NVEC = 8;

   // mask[49:34] flag[33:18] start[17:10] stop[9:2] retrig[1] negate[0]
   localparam logic [49:0] VEC [NVEC] = '{
      {16'h0001, 16'h0001, 8'd0,  8'd1,  1'b0, 1'b0},
      {16'h0100, 16'h0100, 8'd3,  8'd7,  1'b0, 1'b0},
      {16'h0200, 16'h0200, 8'd2,  8'd9,  1'b0, 1'b1},
      {16'h0400, 16'h0400, 8'd5,  8'd5,  1'b0, 1'b0},
      {16'h0080, 16'h0040, 8'd1,  8'd4,  1'b0, 1'b0},
      {16'h0000, 16'hFFFF, 8'd0,  8'd5,  1'b0, 1'b0},
      {16'h8001, 16'h8000, 8'd10, 8'd20, 1'b1, 1'b0},
      {16'h0400, 16'h0400, 8'd6,  8'd2,  1'b0, 1'b1}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NSRC-1:0] trig_flags = '0;
   logic [NSRC-1:0] src_mask = '0;
   logic [CW-1:0]   start_dly = '0;
   logic [CW-1:0]   stop_dly = '0;
   logic            retrig_en = 1'b0;
   logic            negate = 1'b0;
   logic            gate_out;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gate_delay_unit #(.NUM_SRC(NSRC), .CNT_W(CW)) u_gate_delay_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_flags (trig_flags),
      .src_mask   (src_mask),
      .start_dly  (start_dly),
      .stop_dly   (stop_dly),
      .retrig_en  (retrig_en),
      .negate     (negate),
      .gate_out   (gate_out)
   );

   task automatic check1(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: gate_out=%b expected=%b", tag, act, exp);
      end
   endtask

   // Pulse flags_a at edge T, optionally flags_b at edge T+kb (kb=0: none).
   // Expected high for k in [lo1,hi1] or [lo2,hi2], inverted when neg.
   task automatic run_case(input string tag,
                           input logic [NSRC-1:0] mask, input logic [NSRC-1:0] fa,
                           input logic [NSRC-1:0] fb, input int kb,
                           input int st, input int sp, input logic rt, input logic neg,
                           input int lo1, input int hi1, input int lo2, input int hi2);
      int   errs = 0;
      logic exp_v = 1'b0;
      logic act_v = 1'b0;
      src_mask  = mask;
      start_dly = CW'(st);
      stop_dly  = CW'(sp);
      retrig_en = rt;
      negate    = neg;
      repeat (2) @(negedge clk);
      trig_flags = fa;
      @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < SPAN; k++) begin
         logic e;
         e = (((k >= lo1) && (k <= hi1)) || ((k >= lo2) && (k <= hi2))) ^ neg;
         if (gate_out !== e && errs == 0) begin
            exp_v = e;
            act_v = gate_out;
         end
         if (gate_out !== e) errs++;
         trig_flags = (kb != 0 && k + 1 == kb) ? fb : '0;
         @(posedge clk);
         @(negedge clk);
      end
      total++;
      if (errs != 0) begin
         bad++;
         $display("FAIL %s: %0d cycle mismatches, first gate_out=%b expected=%b",
                  tag, errs, act_v, exp_v);
      end
   endtask

   initial begin : main
      // R7: reset state
      repeat (3) @(negedge clk);
      check1("R7 in reset", gate_out, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check1("R7 after reset", gate_out, 1'b0);

      // Table walk: R1, R2, R3, R4, R8
      for (int v = 0; v < NVEC; v++) begin
         logic [15:0] m, f;
         int          s, p;
         logic        hit;
         string       tag;
         m   = VEC[v][49:34];
         f   = VEC[v][33:18];
         s   = int'(VEC[v][17:10]);
         p   = int'(VEC[v][9:2]);
         hit = ((m & f) != 16'h0) && (p > s);
         if ((m & f) == 16'h0)  tag = "R8 masked flag";
         else if (p <= s)       tag = "R3 stop<=start";
         else if (VEC[v][0])    tag = "R4 negate";
         else                   tag = "R1/R2 window";
         if (hit) run_case(tag, m, f, '0, 0, s, p, VEC[v][1], VEC[v][0], s + 1, p, -1, -2);
         else     run_case(tag, m, f, '0, 0, s, p, VEC[v][1], VEC[v][0], -1, -2, -1, -2);
      end

      // R5: second trigger in delay phase ignored without retrigger
      run_case("R5 dead in delay", 16'h0002, 16'h0002, 16'h0002, 3, 5, 10, 1'b0, 1'b0, 6, 10, -1, -2);
      // R6: same with retrigger restarts from edge 3
      run_case("R6 restart in delay", 16'h0002, 16'h0002, 16'h0002, 3, 5, 10, 1'b1, 1'b0, 9, 13, -1, -2);
      // R5: trigger inside open window ignored
      run_case("R5 dead in open", 16'h0300, 16'h0100, 16'h0200, 4, 1, 6, 1'b0, 1'b0, 2, 6, -1, -2);
      // R6: trigger inside open window restarts
      run_case("R6 restart in open", 16'h0300, 16'h0100, 16'h0200, 4, 1, 6, 1'b1, 1'b0, 2, 3, 6, 10);
      // R9: trigger on closing edge ignored
      run_case("R9 closing edge", 16'h0010, 16'h0010, 16'h0010, 4, 1, 3, 1'b0, 1'b0, 2, 3, -1, -2);
      // R9: trigger one edge later accepted
      run_case("R9 next edge", 16'h0010, 16'h0010, 16'h0010, 5, 1, 3, 1'b0, 1'b0, 2, 3, 7, 8);
      // R4: idle level with negate after window
      negate = 1'b1;
      repeat (2) @(negedge clk);
      check1("R4 idle inverted", gate_out, 1'b1);
      // R7: reset mid-window forces low
      negate    = 1'b0;
      src_mask  = 16'h0001;
      start_dly = 16'd0;
      stop_dly  = 16'd8;
      trig_flags = 16'h0001;
      @(negedge clk);
      trig_flags = '0;
      repeat (2) @(negedge clk);
      check1("R2 open before reset", gate_out, 1'b1);
      rst_n = 1'b0;
      @(negedge clk);
      check1("R7 reset mid-window", gate_out, 1'b0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check1("R7 idle after reset", gate_out, 1'b0);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: run hung, actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule